// File: doc/BRIEF.md
# Banked Register Bit-Clear Unit

This block carries out one single-bit clear on an 8-bit data-memory register. It takes a 16-bit instruction word and the current bank select value. From these it finds the bit to clear, the register offset and the bank-override flag, and builds a 12-bit data-memory address. The whole read-modify-write fits inside one instruction cycle, which an external sequencer splits into four phases using a 2-bit phase input. The encoding is 0 = decode, 1 = read, 2 = modify and 3 = write. The phases must arrive in that order.

During decode the unit latches the instruction fields and the bank select value. During read it raises a read strobe on a synchronous RAM port, and the RAM returns data on the next cycle. During modify it captures that data with the chosen bit forced to zero. During write it raises the write strobe and drives the result. Status flags pass through the unit unchanged. A word whose top nibble is not the bit-clear opcode does not touch the RAM at all.

Top module: `bclr_unit`

## Requirements
- R1: An instruction word whose bits 15:12 are not 4'b1001 produces no read strobe and no write strobe in the cycle that follows.
- R2: With the override flag (bit 8) at 0 and the register offset (bits 7:0) below 0x80, the RAM address is {4'h0, offset}.
- R3: With the override flag at 0 and an offset of 0x80 or above, the RAM address is {4'hF, offset}, whatever the bank select value is.
- R4: With the override flag at 1, the RAM address is {bank select value, offset}.
- R5: For a valid instruction, the read strobe is high only in the read phase (phase 1). It is never high at the same time as the write strobe.
- R6: For a valid instruction, the write strobe is high only in the write phase (phase 3), two cycles after the read strobe.
- R7: The written byte equals the byte read, with the bit named by bits 11:9 cleared and all other bits kept. For example, clearing bit 7 of 0xC7 gives 0x47.
- R8: The status flag output always equals the status flag input.
- R9: While reset is asserted, and until the first decode after reset is released, neither strobe is raised, even when the phase input shows write.
- R10: The instruction word and bank select value are sampled only in the decode phase. Changes to them in phases 1 to 3 have no effect on the operation in progress.
- R11: The RAM address driven in the write phase equals the one driven in the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_i | input | 2 | Instruction phase: 0 decode, 1 read, 2 modify, 3 write |
| instr_i | input | 16 | Instruction word, sampled in decode |
| bsr_i | input | 4 | Bank select value, sampled in decode |
| flags_i | input | 5 | Status flags in |
| flags_o | output | 5 | Status flags out, unchanged |
| ram_addr_o | output | 12 | Data-memory address |
| ram_re_o | output | 1 | Read strobe; data is expected on the next cycle |
| ram_rdata_i | input | 8 | Read data from RAM |
| ram_we_o | output | 1 | Write strobe |
| ram_wdata_o | output | 8 | Write data |

## Verification
Several properties are checked by assertions on every cycle:
- the two strobes are never high together;
- each write comes two cycles after a read, at the same address;
- the written offset and opcode match the word seen in decode three cycles earlier;
- the bank comes from the bank select value when the override flag is set;
- the selected bit is zero in the write phase.

Other behaviours can only be shown through the bench's scenarios:
- that all other bits survive the clear;
- the access-bank split at 0x80;
- that late changes to the instruction and bank inputs are ignored;
- that mismatched opcodes and reset leave memory untouched.

The bench shows these by running against a shadow copy of memory.

// File: rtl/bclr_pkg.sv
package bclr_pkg;
  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_MODIFY = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  localparam logic [3:0] BCLR_OPCODE = 4'b1001;
endpackage

// File: rtl/bclr_decode.sv
module bclr_decode
  import bclr_pkg::*;
#(
  parameter int IW  = 16,
  parameter int FW  = 8,
  parameter int XW  = 3,
  parameter int BW  = 4,
  parameter int OPW = 4,
  parameter logic [OPW-1:0] OPCODE = BCLR_OPCODE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_i,
  input  logic [IW-1:0] instr_i,
  input  logic [BW-1:0] bsr_i,
  output logic          valid_o,
  output logic [XW-1:0] bit_o,
  output logic          use_bsr_o,
  output logic [FW-1:0] f_o,
  output logic [BW-1:0] bsr_o
);
  logic          valid_q, valid_d;
  logic [XW-1:0] bit_q, bit_d;
  logic          use_bsr_q, use_bsr_d;
  logic [FW-1:0] f_q, f_d;
  logic [BW-1:0] bsr_q, bsr_d;
  logic          load_en;

  assign load_en = (phase_i == PH_DECODE);

  always_comb begin
    valid_d   = valid_q;
    bit_d     = bit_q;
    use_bsr_d = use_bsr_q;
    f_d       = f_q;
    bsr_d     = bsr_q;
    if (load_en) begin
      valid_d   = (instr_i[IW-1 -: OPW] == OPCODE);
      bit_d     = instr_i[FW+1 +: XW];
      use_bsr_d = instr_i[FW];
      f_d       = instr_i[FW-1:0];
      bsr_d     = bsr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      bit_q     <= '0;
      use_bsr_q <= 1'b0;
      f_q       <= '0;
      bsr_q     <= '0;
    end else begin
      valid_q   <= valid_d;
      bit_q     <= bit_d;
      use_bsr_q <= use_bsr_d;
      f_q       <= f_d;
      bsr_q     <= bsr_d;
    end
  end

  assign valid_o   = valid_q;
  assign bit_o     = bit_q;
  assign use_bsr_o = use_bsr_q;
  assign f_o       = f_q;
  assign bsr_o     = bsr_q;
endmodule

// File: rtl/bclr_addr.sv
module bclr_addr #(
  parameter int FW = 8,
  parameter int BW = 4,
  localparam int AW = FW + BW
) (
  input  logic          use_bsr_i,
  input  logic [FW-1:0] f_i,
  input  logic [BW-1:0] bsr_i,
  output logic [AW-1:0] addr_o
);
  logic [BW-1:0] bank;

  // Override off: lower half of the offset range maps to the first bank,
  // upper half to the last bank.
  always_comb begin
    if (use_bsr_i) bank = bsr_i;
    else           bank = {BW{f_i[FW-1]}};
  end

  assign addr_o = {bank, f_i};
endmodule

// File: rtl/bclr_modify.sv
module bclr_modify
  import bclr_pkg::*;
#(
  parameter int DW = 8,
  localparam int XW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [XW-1:0] bit_i,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] mask;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          cap_en;

  for (genvar gi = 0; gi < DW; gi++) begin : g_mask
    assign mask[gi] = (bit_i == XW'(gi));
  end

  assign cap_en = (phase_i == PH_MODIFY);

  always_comb begin
    wdata_d = wdata_q;
    if (cap_en) wdata_d = rdata_i & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else        wdata_q <= wdata_d;
  end

  assign wdata_o = wdata_q;

  // R7
  cleared_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_WRITE) |-> (wdata_q[bit_i] == 1'b0));
endmodule

// File: rtl/bclr_unit.sv
module bclr_unit
  import bclr_pkg::*;
#(
  parameter int IW  = 16,
  parameter int DW  = 8,
  parameter int FW  = 8,
  parameter int BW  = 4,
  parameter int OPW = 4,
  parameter int FLW = 5,
  localparam int XW = $clog2(DW),
  localparam int AW = FW + BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     phase_i,
  input  logic [IW-1:0]  instr_i,
  input  logic [BW-1:0]  bsr_i,
  input  logic [FLW-1:0] flags_i,
  output logic [FLW-1:0] flags_o,
  output logic [AW-1:0]  ram_addr_o,
  output logic           ram_re_o,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic           ram_we_o,
  output logic [DW-1:0]  ram_wdata_o
);
  phase_e        ph;
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          dec_valid;
  logic [XW-1:0] dec_bit;
  logic          dec_use_bsr;
  logic [FW-1:0] dec_f;
  logic [BW-1:0] dec_bsr;

  assign ph = phase_e'(phase_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bclr_decode #(.IW(IW), .FW(FW), .XW(XW), .BW(BW), .OPW(OPW)) u_decode (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .phase_i   (ph),
    .instr_i   (instr_i),
    .bsr_i     (bsr_i),
    .valid_o   (dec_valid),
    .bit_o     (dec_bit),
    .use_bsr_o (dec_use_bsr),
    .f_o       (dec_f),
    .bsr_o     (dec_bsr)
  );

  bclr_addr #(.FW(FW), .BW(BW)) u_addr (
    .use_bsr_i (dec_use_bsr),
    .f_i       (dec_f),
    .bsr_i     (dec_bsr),
    .addr_o    (ram_addr_o)
  );

  bclr_modify #(.DW(DW)) u_modify (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .phase_i (ph),
    .rdata_i (ram_rdata_i),
    .bit_i   (dec_bit),
    .wdata_o (ram_wdata_o)
  );

  assign ram_re_o = dec_valid && (ph == PH_READ);
  assign ram_we_o = dec_valid && (ph == PH_WRITE);
  assign flags_o  = flags_i;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({ram_re_o, ram_we_o}));

  // R6
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we_o |-> $past(ram_re_o, 2));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we_o |-> (ram_addr_o == $past(ram_addr_o, 2)));

  // R1
  opcode_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we_o |-> ($past(instr_i[IW-1 -: OPW], 3) == BCLR_OPCODE));

  // R10
  offset_from_decode_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ram_we_o |-> (ram_addr_o[FW-1:0] == $past(instr_i[FW-1:0], 3)));

  // R4
  bank_from_bsr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ram_we_o && $past(instr_i[FW], 3)) |-> (ram_addr_o[AW-1 -: BW] == $past(bsr_i, 3)));
endmodule

// File: tb/bclr_unit_bench.sv
module bclr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  phase = 2'd0;
  logic [15:0] instr = 16'h0;
  logic [3:0]  bsr = 4'h0;
  logic [4:0]  flags_in = 5'h0;
  logic [4:0]  flags_out;
  logic [11:0] ram_addr;
  logic        ram_re, ram_we;
  logic [7:0]  ram_rdata = 8'h0;
  logic [7:0]  ram_wdata;

  logic [7:0] ram    [4096];
  logic [7:0] shadow [4096];

  int total = 0;
  int bad   = 0;

  // model state, updated at the decode edge
  bit         m_valid = 1'b0;
  int         m_bit = 0, m_f = 0, m_bsr = 0, m_addr = 0;
  bit         m_a = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bclr_unit u_bclr_unit (
    .clk (clk), .rst_n (rst_n), .phase_i (phase), .instr_i (instr),
    .bsr_i (bsr), .flags_i (flags_in), .flags_o (flags_out),
    .ram_addr_o (ram_addr), .ram_re_o (ram_re), .ram_rdata_i (ram_rdata),
    .ram_we_o (ram_we), .ram_wdata_o (ram_wdata)
  );

  // environment RAM: synchronous read, data one cycle later
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= ram[ram_addr];
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_valid = 1'b0;
    else if (phase == 2'd0) begin
      m_valid = (instr[15:12] == 4'b1001);
      m_bit   = int'(instr[11:9]);
      m_a     = instr[8];
      m_f     = int'(instr[7:0]);
      m_bsr   = int'(bsr);
      if (m_a)            m_addr = m_bsr * 256 + m_f;
      else if (m_f < 128) m_addr = m_f;
      else                m_addr = 15 * 256 + m_f;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    if (m_a) return "R4";
    if (m_f < 128) return "R2";
    return "R3";
  endfunction

  // compare all outputs against the model for the phase currently applied
  task automatic compare_cycle();
    bit exp_re, exp_we;
    logic [7:0] exp_wd;
    exp_re = m_valid && (phase == 2'd1);
    exp_we = m_valid && (phase == 2'd3);
    chk(m_valid ? "R5" : "R1", {31'd0, ram_re}, {31'd0, exp_re});
    chk(m_valid ? "R6" : "R1", {31'd0, ram_we}, {31'd0, exp_we});
    // R10: inputs are scrambled after decode, so these rely on the latched fields
    if (exp_re) chk(mode_tag(), {20'd0, ram_addr}, m_addr);
    if (exp_we) begin
      chk("R11", {20'd0, ram_addr}, m_addr);
      exp_wd = shadow[m_addr] & ~(8'h01 << m_bit);
      chk("R7", {24'd0, ram_wdata}, {24'd0, exp_wd});
      shadow[m_addr] = exp_wd;
    end
    chk("R8", {27'd0, flags_out}, {27'd0, flags_in});
  endtask

  task automatic step(input logic [1:0] ph, input logic [15:0] ins, input logic [3:0] b);
    @(negedge clk);
    if (rst_n) compare_cycle();
    phase    = ph;
    instr    = ins;
    bsr      = b;
    flags_in = 5'($urandom);
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [3:0] b);
    step(2'd0, ins, b);
    for (int p = 1; p < 4; p++) step(2'(p), 16'($urandom), 4'($urandom));
  endtask

  function automatic logic [15:0] mk(input int bt, input bit a, input int f);
    return {4'b1001, 3'(bt), a, 8'(f)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      ram[i]    = 8'((i * 37 + 5) ^ (i >> 4));
      shadow[i] = ram[i];
    end
    ram[12'h210]    = 8'hC7;
    shadow[12'h210] = 8'hC7;

    // R9: reset held with the phase input showing write
    phase = 2'd3;
    instr = mk(0, 1'b1, 8'h10);
    repeat (3) begin
      @(negedge clk);
      chk("R9", {30'd0, ram_re, ram_we}, 32'd0);
    end
    phase = 2'd0;
    instr = 16'h0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(2'd0, 16'h0, 4'h0);

    // R7: 0xC7 with bit 7 cleared, banked address 0x210
    run_op(mk(7, 1'b1, 8'h10), 4'h2);
    step(2'd0, 16'h0, 4'h0);
    chk("R7", {24'd0, ram[12'h210]}, 32'h47);

    // R2: low access half, bank select ignored
    run_op(mk(3, 1'b0, 8'h25), 4'h9);
    // R3: high access half
    run_op(mk(0, 1'b0, 8'hA0), 4'h6);
    run_op(mk(5, 1'b0, 8'h80), 4'h0);
    run_op(mk(1, 1'b0, 8'h7F), 4'hF);
    // R4: banked mode at the edges
    run_op(mk(2, 1'b1, 8'hFF), 4'hF);
    run_op(mk(6, 1'b1, 8'h00), 4'h0);

    // R1: other opcodes leave memory alone
    run_op(16'h8E10, 4'h2);
    run_op(16'hA210, 4'h2);
    run_op(16'h0000, 4'h0);
    step(2'd0, 16'h0, 4'h0);
    chk("R1", {24'd0, ram[12'h010]}, {24'd0, shadow[12'h010]});

    // R7: every bit position on one register, back to back
    for (int bt = 0; bt < 8; bt++) run_op(mk(bt, 1'b1, 8'h33), 4'h5);
    step(2'd0, 16'h0, 4'h0);
    chk("R7", {24'd0, ram[12'h533]}, 32'h0);

    // mixed random traffic
    for (int i = 0; i < 200; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 5 != 0) w[15:12] = 4'b1001;
      run_op(w, 4'($urandom));
    end

    // R9: reset in the middle of an operation, no write follows
    step(2'd0, mk(4, 1'b1, 8'h44), 4'h3);
    step(2'd1, 16'h0, 4'h0);
    @(negedge clk);
    rst_n = 1'b0;
    phase = 2'd3;
    repeat (2) begin
      @(negedge clk);
      chk("R9", {30'd0, ram_re, ram_we}, 32'd0);
    end
    phase = 2'd0;
    instr = 16'h0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(2'd0, 16'h0, 4'h0);
    chk("R9", {24'd0, ram[12'h344]}, {24'd0, shadow[12'h344]});

    run_op(mk(4, 1'b1, 8'h44), 4'h3);
    step(2'd0, 16'h0, 4'h0);

    // final sweep: memory agrees with the shadow copy
    for (int i = 0; i < 4096; i++) begin
      if (ram[i] !== shadow[i]) chk("R7", {24'd0, ram[i]}, {24'd0, shadow[i]});
    end
    chk("R7", 32'd1, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule